// File: doc/BRIEF.md
# Timer Interrupt Pending and Enable Unit

This block gathers interrupt events from four timer subsystems. Each subsystem has four event sources, lettered A to D, so there are sixteen sources in all. Every source owns one bit in a pending register and one bit in an enable register. A one-cycle event pulse sets the source's pending bit. Software clears a pending bit by writing 1 to it. A single interrupt request output goes high while any pending bit has its enable bit set.

Software reaches the two registers over a simple synchronous bus made of an address, a write strobe, write data and combinational read data. Pending bits capture events whatever their enable setting holds. Software can therefore poll sources that are masked. Enabling a source that already has its pending bit set raises the request straight away.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: While reset is held low, the pending register, the enable register and `irq_req` are all 0, and they stay 0 until the first clock edge after reset is released.
- R2: Event input bit i maps to pending bit i and enable bit i. Bits 4k to 4k+3 belong to timer subsystem k+1, holding its sources A, B, C and D in that order with A at bit 4k. For example, bit 5 is subsystem 2, source B.
- R3: An event pulse on bit i sets pending bit i at the next rising clock edge. The bit then stays set until software clears it.
- R4: A write to address 0 (the pending register) clears each pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 keep their value.
- R5: When an event and a write-1 clear reach the same pending bit in the same cycle, the bit ends up set.
- R6: A write to address 1 (the enable register) loads all 16 enable bits from the write data, and a read of address 1 returns them.
- R7: After every clock edge, `irq_req` equals the OR of all bits of (pending AND enable), taken from the register values that edge produced. The output comes straight from a flip-flop.
- R8: An event sets its pending bit even while its enable bit is 0. Setting that enable bit later raises `irq_req` at the edge that loads the enable bit.
- R9: Reads have no side effects. Addresses 2 and 3 read as 0, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 pending, 1 enable, 2 and 3 unused |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 16 | Write data: a 1s mask for pending, the new value for enable |
| bus_rdata | output | 16 | Combinational read data for the selected register |
| evt_pulse | input | 16 | One-cycle event pulses, one per source |
| irq_req | output | 1 | Registered combined interrupt request |

## Verification
The hardest case to reach from the ports is an event and a write-1 clear landing on the same pending bit in the same cycle. Random stimulus seldom lines up both on one bit, and the result is only visible on the next read. The bench forces this collision with directed steps on a single bit. Its random phase draws the write mask and the event vector at the same time, with fairly dense events, so that overlaps also occur across many bit positions. A second case is enabling a source that is already pending while no new event arrives. Directed stimulus holds every enable bit at 0, lets events collect, and only then writes the enable register.

// File: rtl/tmr_irq_pkg.sv
// Package: shared constants for the timer interrupt unit.
// Assumes: register addresses fit in the bus address width chosen at the top.
package tmr_irq_pkg;
    localparam int unsigned REG_PEND = 0;  // pending register address
    localparam int unsigned REG_EN   = 1;  // enable register address
endpackage

// File: rtl/tmr_irq_pend_unit.sv
// Module: pending bits for one timer subsystem.
// Each bit is set by its event and cleared by a write-1 mask; set wins.
// Assumes: clr_i is already qualified by the bus write to the pending address.
module tmr_irq_pend_unit #(
    parameter int unsigned SRC = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SRC-1:0] set_i,
    input  logic [SRC-1:0] clr_i,
    output logic [SRC-1:0] pend_o,
    output logic [SRC-1:0] pend_d_o
);
    logic [SRC-1:0] pend_q;

    // Next state: clear by mask first, then OR in events so set wins.
    always_comb begin
        pend_d_o = (pend_q & ~clr_i) | set_i;
    end

    // Pending storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d_o;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/tmr_irq_en_reg.sv
// Module: enable register, loaded whole from the bus.
// Assumes: wr_i is already qualified by the bus write to the enable address.
module tmr_irq_en_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] en_o,
    output logic [W-1:0] en_d_o
);
    logic [W-1:0] en_q;

    // Next state: take write data on a write, else hold.
    always_comb begin
        en_d_o = wr_i ? wdata_i : en_q;
    end

    // Enable storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d_o;
    end

    assign en_o = en_q;
endmodule

// File: rtl/tmr_irq_merge.sv
// Module: combines pending and enable into one registered request.
// Works from the next-state values, so the flop agrees with the registers
// after every edge. Assumes both inputs are next-state vectors.
module tmr_irq_merge #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pend_d_i,
    input  logic [W-1:0] en_d_i,
    output logic         irq_o
);
    logic irq_q;

    // Request flop: a glitch-free OR of the enabled pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(pend_d_i & en_d_i);
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/tmr_irq_ctrl.sv
// Module: top of the timer interrupt pending/enable unit.
// Decodes the register bus, builds one pending slice per subsystem,
// and drives the combined request. Reads are combinational and side-effect free.
// Assumes: event pulses are synchronous to clk.
module tmr_irq_ctrl #(
    parameter int unsigned N_UNITS = 4,
    parameter int unsigned N_SRC   = 4,
    parameter int unsigned ADDR_W  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [N_UNITS*N_SRC-1:0]   bus_wdata,
    output logic [N_UNITS*N_SRC-1:0]   bus_rdata,
    input  logic [N_UNITS*N_SRC-1:0]   evt_pulse,
    output logic                       irq_req
);
    import tmr_irq_pkg::*;

    localparam int unsigned W = N_UNITS * N_SRC;

    logic         sel_pend;
    logic         sel_en;
    logic [W-1:0] clr_mask;
    logic [W-1:0] pend_q;
    logic [W-1:0] pend_d;
    logic [W-1:0] en_q;
    logic [W-1:0] en_d;

    // Address decode for the two implemented registers.
    always_comb begin
        sel_pend = (bus_addr == ADDR_W'(REG_PEND));
        sel_en   = (bus_addr == ADDR_W'(REG_EN));
        clr_mask = (bus_wr && sel_pend) ? bus_wdata : '0;
    end

    // One pending slice per timer subsystem.
    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        tmr_irq_pend_unit #(.SRC(N_SRC)) u_pend (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (evt_pulse[u*N_SRC +: N_SRC]),
            .clr_i    (clr_mask[u*N_SRC +: N_SRC]),
            .pend_o   (pend_q[u*N_SRC +: N_SRC]),
            .pend_d_o (pend_d[u*N_SRC +: N_SRC])
        );
    end

    tmr_irq_en_reg #(.W(W)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr && sel_en),
        .wdata_i (bus_wdata),
        .en_o    (en_q),
        .en_d_o  (en_d)
    );

    tmr_irq_merge #(.W(W)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_d_i (pend_d),
        .en_d_i   (en_d),
        .irq_o    (irq_req)
    );

    // Read mux; unused addresses return zero.
    always_comb begin
        if (sel_pend)    bus_rdata = pend_q;
        else if (sel_en) bus_rdata = en_q;
        else             bus_rdata = '0;
    end
endmodule

// File: rtl/tmr_irq_ctrl_chk.sv
// Checker: temporal properties of the timer interrupt unit, bound to the top.
module tmr_irq_ctrl_chk #(
    parameter int unsigned W      = 16,
    parameter int unsigned ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      evt_pulse,
    input logic [W-1:0]      pend_q,
    input logic [W-1:0]      en_q,
    input logic              irq_req
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0 && en_q == '0 && !irq_req)); // R1

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != '0) |=> ((pend_q & $past(evt_pulse)) == $past(evt_pulse))); // R3

    AST_W1_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(0))
        |=> ((pend_q & $past(bus_wdata & ~evt_pulse)) == '0)); // R4

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse == '0 && !(bus_wr && bus_addr == ADDR_W'(0))) |=> $stable(pend_q)); // R9

    AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(1)) |=> (en_q == $past(bus_wdata))); // R6

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_req == |(pend_q & en_q))); // R7
endmodule

bind tmr_irq_ctrl tmr_irq_ctrl_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .evt_pulse (evt_pulse),
    .pend_q    (pend_q),
    .en_q      (en_q),
    .irq_req   (irq_req)
);

// File: tb/tmr_irq_ctrl_bench.sv
`timescale 1ns/1ps
module tmr_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] evt_pulse = '0;
    logic        irq_req;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_pend = '0;
    logic [15:0] m_en = '0;

    always #2 clk = ~clk;

    tmr_irq_ctrl u_tmr_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_pulse(evt_pulse), .irq_req(irq_req)
    );

    function automatic logic [15:0] pend_next(logic [15:0] p, logic [1:0] a,
                                              logic w, logic [15:0] d, logic [15:0] e);
        return (p & ~((w && a == 2'd0) ? d : 16'h0)) | e;
    endfunction

    function automatic logic [15:0] en_next(logic [15:0] n, logic [1:0] a,
                                            logic w, logic [15:0] d);
        return (w && a == 2'd1) ? d : n;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus/event cycle, then model update and request check at negedge.
    task automatic step(logic [1:0] a, logic w, logic [15:0] d, logic [15:0] e);
        bus_addr = a; bus_wr = w; bus_wdata = d; evt_pulse = e;
        @(posedge clk);
        m_pend = pend_next(m_pend, a, w, d, e);
        m_en   = en_next(m_en, a, w, d);
        @(negedge clk);
        bus_wr = 1'b0; evt_pulse = '0;
        check("R7 irq", {15'b0, irq_req}, {15'b0, |(m_pend & m_en)});
    endtask

    task automatic rd(string req, logic [1:0] a, logic [15:0] exp);
        bus_wr = 1'b0; evt_pulse = '0; bus_addr = a;
        #0.5;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5e_a7c3));
        // R1: held reset, events and writes ignored
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 16'hFFFF; evt_pulse = 16'hFFFF;
        repeat (3) @(negedge clk);
        bus_wr = 1'b0; evt_pulse = '0;
        rd("R1 pend", 2'd0, 16'h0);
        rd("R1 en", 2'd1, 16'h0);
        check("R1 irq", {15'b0, irq_req}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd("R1 pend after release", 2'd0, 16'h0);

        // R2/R3: bit 5 = subsystem 2 source B
        step(2'd0, 1'b0, 16'h0, 16'h0020);
        rd("R2 R3 bit5", 2'd0, 16'h0020);
        step(2'd0, 1'b0, 16'h0, 16'h0000);
        rd("R3 stays set", 2'd0, 16'h0020);
        step(2'd0, 1'b0, 16'h0, 16'h8001);
        rd("R2 edges", 2'd0, 16'h8021);

        // R4: write 0 keeps, write 1 clears
        step(2'd0, 1'b1, 16'h0000, 16'h0);
        rd("R4 write0", 2'd0, 16'h8021);
        step(2'd0, 1'b1, 16'h0020, 16'h0);
        rd("R4 write1", 2'd0, 16'h8001);

        // R5: collision on bit 0, clear bit 15 alongside
        step(2'd0, 1'b1, 16'h8001, 16'h0001);
        rd("R5 set wins", 2'd0, 16'h0001);

        // R8: masked capture, then enable raises request
        step(2'd0, 1'b0, 16'h0, 16'h0400);
        check("R8 masked irq", {15'b0, irq_req}, 16'h0);
        step(2'd1, 1'b1, 16'h0400, 16'h0);
        check("R8 enable irq", {15'b0, irq_req}, 16'h1);
        rd("R6 en readback", 2'd1, 16'h0400);
        step(2'd0, 1'b1, 16'h0400, 16'h0);
        check("R7 irq drop", {15'b0, irq_req}, 16'h0);

        // R9: unused addresses, repeated reads
        step(2'd2, 1'b1, 16'hFFFF, 16'h0);
        step(2'd3, 1'b1, 16'hFFFF, 16'h0);
        rd("R9 addr2", 2'd2, 16'h0);
        rd("R9 addr3", 2'd3, 16'h0);
        rd("R9 pend", 2'd0, m_pend);
        rd("R9 pend reread", 2'd0, m_pend);
        rd("R9 en", 2'd1, m_en);

        // Random phase: R3 R4 R5 R6 R7
        for (int i = 0; i < 400; i++) begin
            logic [1:0]  a;
            logic [15:0] d;
            logic [15:0] e;
            a = 2'($urandom_range(0, 3));
            d = 16'($urandom);
            e = 16'($urandom) & 16'($urandom);
            step(a, 1'($urandom), d, e);
            rd("R3 R4 R5 rand pend", 2'd0, m_pend);
            rd("R6 rand en", 2'd1, m_en);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule